// File: doc/BRIEF.md
# Split-Byte Conversion Result Register with Read Lock

This block holds the most recent 10-bit conversion result and serves it to software as two bytes on an 8-bit read bus: a low byte and a high byte, each selected by its own read strobe. An alignment control chooses how the 10 bits are packed. Right alignment puts the result in the bottom of the 16-bit pair. Left alignment puts it in the top of the pair, so reading the high byte alone yields an 8-bit result.

To keep the two bytes coherent, a low-byte read freezes the stored result until the high byte is read. Any result that arrives while the store is frozen is discarded. The completion flag still rises for every finished conversion, including discarded ones, and stays set until it is acknowledged.

Top module: `resreg_top`

## Requirements
- R1: After reset the stored result is zero, the lock is open and `done_flag` is 0.
- R2: With `align_left`=0, a low read returns result bits 7..0, and a high read returns result bits 9..8 in bit positions 1..0 with bits 7..2 as zero.
- R3: With `align_left`=1, a high read returns result bits 9..2, and a low read returns result bits 1..0 in bit positions 7..6 with bits 5..0 as zero.
- R4: A change of `align_left` changes `rd_data` in the same cycle, using the stored result and no new conversion.
- R5: `rd_data` is zero when neither strobe is high. When both strobes are high, the low byte is returned.
- R6: A `res_valid` pulse while the lock is open and `rd_lo` is low stores `res_data`, which is readable from the next cycle on.
- R7: A cycle with `rd_lo` high closes the lock from the next cycle on. A result that arrives in that cycle, or while the lock is closed, leaves the stored result unchanged.
- R8: A cycle with `rd_hi` high opens the lock from the next cycle on, and this takes priority over `rd_lo`. A result that arrives in the same cycle as that `rd_hi` while the lock is closed is still dropped.
- R9: A high read with no low read before it leaves the lock open, so later results are still stored.
- R10: `done_flag` is set in the cycle after each `res_valid`, whether the result was stored or dropped. It is cleared in the cycle after `flag_ack`, and a result arriving in the same cycle as `flag_ack` keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Single-cycle pulse: a conversion has finished |
| res_data | input | 10 | Result that goes with `res_valid` |
| rd_lo | input | 1 | Read strobe for the low byte |
| rd_hi | input | 1 | Read strobe for the high byte |
| align_left | input | 1 | 0 = right aligned, 1 = left aligned |
| flag_ack | input | 1 | Clears the completion flag |
| rd_data | output | 8 | Byte selected by the strobes (combinational) |
| done_flag | output | 1 | Conversion-complete flag |

## Verification
The assertions assume that every strobe and `res_valid` is a single-cycle event, sampled only at the rising edge. They also assume that `res_data` matters only in a cycle where `res_valid` is high. The bench changes all inputs on the falling edge and holds them for one full cycle. Its random phase draws strobes and result pulses independently, so locked drops, same-cycle read and result collisions, and acknowledge races all occur. Every input stays a plain level sampled once per cycle.

// File: rtl/resreg_pkg.sv
package resreg_pkg;
    localparam int RES_W = 10;
    localparam int BUS_W = 8;
    localparam int PAIR_W = 2 * BUS_W;
    localparam int PAD_W = PAIR_W - RES_W;

    typedef enum logic { ALIGN_RIGHT = 1'b0, ALIGN_LEFT = 1'b1 } align_e;
    typedef enum logic [1:0] { SEL_NONE, SEL_LO, SEL_HI } sel_e;

    typedef struct packed {
        logic [BUS_W-1:0] hi;
        logic [BUS_W-1:0] lo;
    } byte_pair_t;

    function automatic byte_pair_t split_result(logic [RES_W-1:0] r, align_e a);
        logic [PAIR_W-1:0] wide;
        if (a == ALIGN_LEFT) wide = {r, {PAD_W{1'b0}}};
        else                 wide = {{PAD_W{1'b0}}, r};
        return byte_pair_t'(wide);
    endfunction
endpackage

// File: rtl/resreg_lock.sv
module resreg_lock (
    input  logic clk,
    input  logic rst,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst)        locked <= 1'b0;
        else if (rd_hi) locked <= 1'b0;
        else if (rd_lo) locked <= 1'b1;
    end

    assert_lo_locks_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !rd_hi) |=> locked);
    assert_hi_opens_R8: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> !locked);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!rd_lo && !rd_hi) |=> $stable(locked));
endmodule

// File: rtl/resreg_store.sv
module resreg_store
    import resreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             locked,
    input  logic             rd_lo,
    input  logic             flag_ack,
    output logic [RES_W-1:0] result_q,
    output logic             done_q
);
    logic accept;
    assign accept = res_valid && !locked && !rd_lo;

    always_ff @(posedge clk) begin
        if (rst)         result_q <= '0;
        else if (accept) result_q <= res_data;
    end

    always_ff @(posedge clk) begin
        if (rst)            done_q <= 1'b0;
        else if (res_valid) done_q <= 1'b1;
        else if (flag_ack)  done_q <= 1'b0;
    end

    assert_take_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !locked && !rd_lo) |=> result_q == $past(res_data));
    assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (locked || rd_lo) |=> $stable(result_q));
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> done_q);
    assert_flag_clr_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_ack && !res_valid) |=> !done_q);
endmodule

// File: rtl/resreg_format.sv
module resreg_format
    import resreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RES_W-1:0] result_q,
    input  logic             align_left,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [BUS_W-1:0] rd_data
);
    sel_e       sel;
    byte_pair_t pair;

    always_comb begin
        if (rd_lo)      sel = SEL_LO;
        else if (rd_hi) sel = SEL_HI;
        else            sel = SEL_NONE;
    end

    assign pair = split_result(result_q, align_e'(align_left));

    always_comb begin
        unique case (sel)
            SEL_LO:  rd_data = pair.lo;
            SEL_HI:  rd_data = pair.hi;
            default: rd_data = '0;
        endcase
    end

    assert_right_pad_R2: assert property (@(posedge clk) disable iff (rst)
        (!align_left && rd_hi && !rd_lo) |-> rd_data[BUS_W-1:RES_W-BUS_W] == '0);
    assert_left_pad_R3: assert property (@(posedge clk) disable iff (rst)
        (align_left && rd_lo) |-> rd_data[PAD_W-1:0] == '0);
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!rd_lo && !rd_hi) |-> rd_data == '0);
endmodule

// File: rtl/resreg_top.sv
module resreg_top
    import resreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             rd_lo,
    input  logic             rd_hi,
    input  logic             align_left,
    input  logic             flag_ack,
    output logic [BUS_W-1:0] rd_data,
    output logic             done_flag
);
    logic             locked;
    logic [RES_W-1:0] result_q;

    resreg_lock u_lock (
        .clk(clk), .rst(rst), .rd_lo(rd_lo), .rd_hi(rd_hi), .locked(locked)
    );

    resreg_store u_store (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .locked(locked), .rd_lo(rd_lo), .flag_ack(flag_ack),
        .result_q(result_q), .done_q(done_flag)
    );

    resreg_format u_format (
        .clk(clk), .rst(rst), .result_q(result_q), .align_left(align_left),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data)
    );

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!done_flag && !locked && result_q == '0));
endmodule

// File: tb/resreg_top_tb_top.sv
`timescale 1ns/1ps
module resreg_top_tb_top;
    localparam real HALF = 4.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       res_valid = 1'b0;
    logic [9:0] res_data = '0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic       align_left = 1'b0;
    logic       flag_ack = 1'b0;
    logic [7:0] rd_data;
    logic       done_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int m_data = 0;
    bit m_lock = 1'b0;
    bit m_flag = 1'b0;

    always #(HALF) clk = ~clk;

    resreg_top dut_i (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .align_left(align_left),
        .flag_ack(flag_ack), .rd_data(rd_data), .done_flag(done_flag)
    );

    function automatic int exp_byte(bit lo, bit hi, bit left, int d);
        if (lo) return left ? ((d & 3) << 6) : (d & 255);
        if (hi) return left ? ((d >> 2) & 255) : ((d >> 8) & 3);
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit v, int d, bit lo, bit hi, bit left, bit ack, string tag);
        bit take;
        @(negedge clk);
        res_valid = v; res_data = d[9:0]; rd_lo = lo; rd_hi = hi;
        align_left = left; flag_ack = ack;
        #1;
        check(tag, int'(rd_data), exp_byte(lo, hi, left, m_data));
        check("R10", int'(done_flag), int'(m_flag));
        @(posedge clk);
        take = v && !m_lock && !lo;
        if (take) m_data = d & 1023;
        if (hi) m_lock = 1'b0; else if (lo) m_lock = 1'b1;
        if (v) m_flag = 1'b1; else if (ack) m_flag = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        step(0, 0, 1, 0, 0, 0, "R1");
        step(0, 0, 0, 1, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R5");
        // R6 store while open, R2 right-aligned readout
        step(1, 10'h2A5, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 0, 0, "R2");
        // R7 results while locked dropped
        step(1, 10'h15A, 0, 0, 0, 0, "R7");
        step(1, 10'h3FF, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 1, 0, 0, "R2");
        step(0, 0, 1, 0, 0, 0, "R7");
        // R8 result in same cycle as unlocking read is dropped
        step(1, 10'h0C3, 0, 1, 0, 0, "R8");
        step(1, 10'h1E7, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 0, 0, "R8");
        // R7 result in same cycle as low read dropped
        step(1, 10'h222, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 1, 0, "R7");
        // R3 left alignment, R9 high-only reads keep lock open
        step(1, 10'h3A9, 0, 1, 1, 0, "R9");
        step(0, 0, 0, 1, 1, 0, "R3");
        step(1, 10'h155, 0, 1, 1, 0, "R9");
        step(0, 0, 1, 0, 1, 0, "R3");
        step(0, 0, 0, 1, 1, 0, "R3");
        // R4 alignment switch without a new result
        step(0, 0, 0, 1, 0, 0, "R4");
        step(0, 0, 1, 0, 1, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R4");
        // R5 both strobes: low byte wins, high unlocks
        step(0, 0, 1, 1, 0, 0, "R5");
        step(1, 10'h0F0, 0, 0, 0, 0, "R8");
        // R10 ack and set-over-ack race
        step(0, 0, 0, 0, 0, 1, "R10");
        step(1, 10'h001, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        // mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 3) == 0, int'($urandom % 1024), ($urandom % 4) == 0,
                 ($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 5) == 0, "R6");
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(HALF * 2.0 * 150000.0);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule